// File: doc/BRIEF.md
# Byte-to-Halfword Bus Width Adapter

This block connects a byte-addressed host bus to an external asynchronous memory whose data bus is either 8 or 16 bits wide. A static mode input selects the width. For every host read or write strobe it works out the device word address, places write bytes on the correct data lanes with per-lane drive enables, and returns read data with the right byte brought down to the low end of the host read bus.

In narrow mode the host byte address passes straight through and only the low lane carries data. In wide mode the lowest host address bit selects a byte inside a 16-bit device word. It is never driven to the device. It steers writes to one lane and picks which half of the fetched word a byte read returns. Halfword requests that cannot be served in one device access are refused with an alignment error pulse and never reach the device.

All device-side outputs are registered. The device is expected to present read data during the cycle its read strobe is high. That data is captured into a register and handed back with a one-cycle valid pulse.

Top module: `bwa_top`

## Requirements
- R1: While reset is high and in the first cycle after it, d_re, d_we, d_lane_oe, h_rvalid and h_align_err are all 0.
- R2: In narrow mode (mode_wide=0) a byte access drives d_addr equal to h_addr. A byte write puts h_wdata[7:0] on d_wdata[7:0], sets d_lane_oe=2'b01 and drives d_wdata[15:8] to 0.
- R3: In wide mode (mode_wide=1) d_addr equals h_addr shifted right by one, with 0 in the top bit, so host bit 0 never reaches the device.
- R4: In wide mode a byte read at an even host address returns device bits 7..0 in h_rdata[7:0], and one at an odd address returns device bits 15..8 of the same word. h_rdata[15:8] is 0 for both.
- R5: In wide mode a halfword write at host address 2N drives d_addr=N, d_wdata=h_wdata and d_lane_oe=2'b11. A halfword read there returns the full device word.
- R6: In wide mode a byte write drives h_wdata[7:0] on lane 0 (d_lane_oe=2'b01) for an even address or on lane 1 (d_lane_oe=2'b10) for an odd one. The unselected lane carries 0 and d_lane_oe is 0 whenever d_we is 0.
- R7: A halfword request (h_half=1) at an odd address in wide mode, or any halfword request in narrow mode, raises h_align_err for one cycle and issues neither d_re nor d_we.
- R8: Device strobes, address, lanes and the error flag appear in the cycle after the host strobe. Read data appears on h_rdata with a one-cycle h_rvalid pulse in the cycle after d_re.
- R9: If h_rd and h_wr are both high, only the write is issued, and no h_rvalid follows.
- R10: In narrow mode a byte read returns d_rdata[7:0] in h_rdata[7:0] with h_rdata[15:8]=0, whatever the upper device lane carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | Static width select: 1 = 16-bit device, 0 = 8-bit device |
| h_addr | input | HADDR_W | Host byte address |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_half | input | 1 | Access size: 1 = halfword, 0 = byte |
| h_wdata | input | 16 | Host write data (byte writes use bits 7..0) |
| h_rdata | output | 16 | Returned read data |
| h_rvalid | output | 1 | One-cycle pulse marking h_rdata valid |
| h_align_err | output | 1 | One-cycle pulse for a refused halfword request |
| d_addr | output | HADDR_W | Device word or byte address |
| d_re | output | 1 | Device read strobe |
| d_we | output | 1 | Device write strobe |
| d_wdata | output | 16 | Device write data, lane 1 = bits 15..8 |
| d_lane_oe | output | 2 | Per-lane write drive enable |
| d_rdata | input | 16 | Device read data, valid while d_re is high |

## Verification
A host strobe applied before a rising edge produces the device strobes, address, lane enables and error flag just after that edge. Read data and its valid pulse follow one edge later. The bench drives each request on a falling edge for exactly one cycle, checks the device side at the next falling edge and checks the return path at the falling edge after that, so each result is sampled in the cycle it is due and no request overlaps the one before. A shadow memory updated from the expected write steering predicts every read, and a device model written by the actual lane enables serves those reads, so any misplaced write shows up as wrong read data later.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int unsigned NLANES = 2;

  // Information kept alongside an issued device read to shape its return.
  typedef struct packed {
    logic odd;   // wide mode, upper byte selected
    logic half;  // full word requested
  } rd_tag_t;
endpackage

// File: rtl/bwa_addr_map.sv
module bwa_addr_map #(
  parameter int unsigned HADDR_W = 20
) (
  input  logic               mode_wide,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic               h_half,
  output logic [HADDR_W-1:0] dev_addr,
  output logic               misalign
);
  always_comb begin
    if (mode_wide) dev_addr = {1'b0, h_addr[HADDR_W-1:1]};
    else           dev_addr = h_addr;
  end

  // Halfword needs a wide device and an even byte address.
  assign misalign = h_half & (~mode_wide | h_addr[0]);
endmodule

// File: rtl/bwa_lane_steer.sv
module bwa_lane_steer #(
  parameter int unsigned LANE_W = 8
) (
  input  logic                               mode_wide,
  input  logic                               a0,
  input  logic                               half,
  input  logic [bwa_pkg::NLANES*LANE_W-1:0]  wdata,
  output logic [bwa_pkg::NLANES*LANE_W-1:0]  lane_data,
  output logic [bwa_pkg::NLANES-1:0]         lane_sel
);
  localparam int unsigned NL = bwa_pkg::NLANES;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic sel;
    always_comb begin
      if (mode_wide && half) sel = 1'b1;
      else if (mode_wide)    sel = (a0 == l[0]);
      else                   sel = (l == 0);
    end
    assign lane_sel[l] = sel;
    assign lane_data[l*LANE_W +: LANE_W] =
      !sel ? '0 : (half ? wdata[l*LANE_W +: LANE_W] : wdata[LANE_W-1:0]);
  end
endmodule

// File: rtl/bwa_read_return.sv
module bwa_read_return #(
  parameter int unsigned LANE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cap,
  input  bwa_pkg::rd_tag_t                  tag,
  input  logic [bwa_pkg::NLANES*LANE_W-1:0] dev_rdata,
  output logic [bwa_pkg::NLANES*LANE_W-1:0] rdata,
  output logic                              rvalid
);
  localparam int unsigned DW = bwa_pkg::NLANES * LANE_W;

  logic [DW-1:0] shaped;

  always_comb begin
    if (tag.half)     shaped = dev_rdata;
    else if (tag.odd) shaped = {{LANE_W{1'b0}}, dev_rdata[DW-1 -: LANE_W]};
    else              shaped = {{LANE_W{1'b0}}, dev_rdata[LANE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= cap;
      if (cap) rdata <= shaped;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    cap |=> rvalid); // R8
  AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(cap)); // R8
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cap && !tag.half) |=> (rdata[DW-1 -: LANE_W] == '0)); // R4
endmodule

// File: rtl/bwa_top.sv
module bwa_top #(
  parameter int unsigned HADDR_W = 20,
  parameter int unsigned LANE_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_wide,
  input  logic [HADDR_W-1:0]      h_addr,
  input  logic                    h_rd,
  input  logic                    h_wr,
  input  logic                    h_half,
  input  logic [2*LANE_W-1:0]     h_wdata,
  output logic [2*LANE_W-1:0]     h_rdata,
  output logic                    h_rvalid,
  output logic                    h_align_err,
  output logic [HADDR_W-1:0]      d_addr,
  output logic                    d_re,
  output logic                    d_we,
  output logic [2*LANE_W-1:0]     d_wdata,
  output logic [1:0]              d_lane_oe,
  input  logic [2*LANE_W-1:0]     d_rdata
);
  import bwa_pkg::*;
  localparam int unsigned DW = NLANES * LANE_W;

  logic [HADDR_W-1:0] map_addr;
  logic               misalign;
  logic [DW-1:0]      steer_data;
  logic [NLANES-1:0]  steer_sel;
  logic               req, do_wr, do_rd;
  rd_tag_t            tag_q;

  bwa_addr_map #(.HADDR_W(HADDR_W)) u_map (
    .mode_wide (mode_wide),
    .h_addr    (h_addr),
    .h_half    (h_half),
    .dev_addr  (map_addr),
    .misalign  (misalign)
  );

  bwa_lane_steer #(.LANE_W(LANE_W)) u_steer (
    .mode_wide (mode_wide),
    .a0        (h_addr[0]),
    .half      (h_half),
    .wdata     (h_wdata),
    .lane_data (steer_data),
    .lane_sel  (steer_sel)
  );

  assign req   = h_rd | h_wr;
  assign do_wr = h_wr & ~misalign;
  assign do_rd = h_rd & ~h_wr & ~misalign;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_addr      <= '0;
      d_re        <= 1'b0;
      d_we        <= 1'b0;
      d_wdata     <= '0;
      d_lane_oe   <= '0;
      h_align_err <= 1'b0;
      tag_q       <= '0;
    end else begin
      d_re        <= do_rd;
      d_we        <= do_wr;
      h_align_err <= req & misalign;
      d_wdata     <= do_wr ? steer_data : '0;
      d_lane_oe   <= do_wr ? steer_sel  : '0;
      if (req && !misalign) d_addr <= map_addr;
      if (do_rd) begin
        tag_q.odd  <= mode_wide & h_addr[0];
        tag_q.half <= h_half;
      end
    end
  end

  bwa_read_return #(.LANE_W(LANE_W)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .cap       (d_re),
    .tag       (tag_q),
    .dev_rdata (d_rdata),
    .rdata     (h_rdata),
    .rvalid    (h_rvalid)
  );

  AST_ERR_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    h_align_err |-> (!d_re && !d_we)); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({d_re, d_we})); // R9
  AST_WIDE_ADDR_SHIFT: assert property (@(posedge clk) disable iff (rst)
    ((d_re || d_we) && mode_wide) |-> (d_addr == ($past(h_addr) >> 1))); // R3
  AST_NARROW_LANE0: assert property (@(posedge clk) disable iff (rst)
    (d_we && !mode_wide) |-> (d_lane_oe == 2'b01)); // R2
  AST_IDLE_LANES_QUIET: assert property (@(posedge clk) disable iff (rst)
    !d_we |-> (d_lane_oe == 2'b00)); // R6
  AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
    d_we |-> (d_lane_oe != 2'b00)); // R5
endmodule

// File: tb/bwa_top_bench.sv
module bwa_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_wide = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic          h_rd = 1'b0, h_wr = 1'b0, h_half = 1'b0;
  logic [15:0]   h_wdata = '0;
  logic [15:0]   h_rdata;
  logic          h_rvalid, h_align_err;
  logic [AW-1:0] d_addr;
  logic          d_re, d_we;
  logic [15:0]   d_wdata;
  logic [1:0]    d_lane_oe;
  logic [15:0]   d_rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] ref_mem [256];
  logic [15:0] dev_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  bwa_top #(.HADDR_W(AW), .LANE_W(8)) u_bwa_top (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .h_addr(h_addr),
    .h_rd(h_rd), .h_wr(h_wr), .h_half(h_half), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_align_err(h_align_err),
    .d_addr(d_addr), .d_re(d_re), .d_we(d_we), .d_wdata(d_wdata),
    .d_lane_oe(d_lane_oe), .d_rdata(d_rdata)
  );

  function automatic logic [15:0] init_word(int i);
    return 16'(i * 16'h0101 ^ 16'h5A3C ^ (i << 7));
  endfunction

  // Device model: asynchronous read, lane-enabled write.
  assign d_rdata = dev_mem[d_addr[7:0]];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) dev_mem[i] <= init_word(i);
    end else if (d_we) begin
      if (d_lane_oe[0]) dev_mem[d_addr[7:0]][7:0]  <= d_wdata[7:0];
      if (d_lane_oe[1]) dev_mem[d_addr[7:0]][15:8] <= d_wdata[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_daddr(logic wide, logic [AW-1:0] a);
    return wide ? {1'b0, a[AW-1:1]} : a;
  endfunction

  function automatic logic exp_err(logic wide, logic half, logic [AW-1:0] a);
    return half && (!wide || a[0]);
  endfunction

  function automatic logic [1:0] exp_oe(logic wide, logic half, logic a0);
    if (wide && half) return 2'b11;
    if (wide)         return a0 ? 2'b10 : 2'b01;
    return 2'b01;
  endfunction

  function automatic logic [15:0] exp_wd(logic wide, logic half, logic a0, logic [15:0] wd);
    if (wide && half) return wd;
    if (wide && a0)   return {wd[7:0], 8'h00};
    return {8'h00, wd[7:0]};
  endfunction

  function automatic logic [15:0] exp_rd(logic wide, logic half, logic a0, logic [15:0] w);
    if (wide && half) return w;
    if (wide && a0)   return {8'h00, w[15:8]};
    return {8'h00, w[7:0]};
  endfunction

  task automatic do_reset(input logic wide);
    @(negedge clk);
    rst = 1'b1;
    mode_wide = wide;
    for (int i = 0; i < 256; i++) ref_mem[i] = init_word(i);
    repeat (2) @(negedge clk);
    chk(!d_re && !d_we && d_lane_oe == 0 && !h_rvalid && !h_align_err,
        "R1", "outputs in reset", {d_re, d_we, d_lane_oe, h_rvalid, h_align_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!d_re && !d_we && d_lane_oe == 0 && !h_rvalid && !h_align_err,
        "R1", "outputs after reset", {d_re, d_we, d_lane_oe, h_rvalid, h_align_err}, 0);
  endtask

  // One host request, held for one cycle; device side checked one cycle
  // later, return path one cycle after that.
  task automatic access(input logic rd, input logic wr, input logic half,
                        input logic [AW-1:0] a, input logic [15:0] wd);
    logic wide, err, x_re, x_we;
    logic [7:0] idx;
    logic [15:0] x_rdata;
    wide  = mode_wide;
    err   = (rd || wr) && exp_err(wide, half, a);
    x_we  = wr && !err;
    x_re  = rd && !wr && !err;
    idx   = exp_daddr(wide, a)[7:0];
    x_rdata = exp_rd(wide, half, a[0], ref_mem[idx]);
    h_addr = a; h_rd = rd; h_wr = wr; h_half = half; h_wdata = wd;
    @(negedge clk);
    h_rd = 1'b0; h_wr = 1'b0;
    chk(h_align_err == err, "R7", "align error", 32'(h_align_err), 32'(err));
    chk(d_re == x_re, "R9", "d_re", 32'(d_re), 32'(x_re));
    chk(d_we == x_we, "R8", "d_we", 32'(d_we), 32'(x_we));
    if (x_re || x_we)
      chk(d_addr == exp_daddr(wide, a), wide ? "R3" : "R2", "d_addr",
          32'(d_addr), 32'(exp_daddr(wide, a)));
    if (x_we) begin
      chk(d_lane_oe == exp_oe(wide, half, a[0]), wide ? (half ? "R5" : "R6") : "R2",
          "lane enables", 32'(d_lane_oe), 32'(exp_oe(wide, half, a[0])));
      chk(d_wdata == exp_wd(wide, half, a[0], wd), wide ? (half ? "R5" : "R6") : "R2",
          "lane data", 32'(d_wdata), 32'(exp_wd(wide, half, a[0], wd)));
      if (wide && half)     ref_mem[idx] = wd;
      else if (wide && a[0]) ref_mem[idx][15:8] = wd[7:0];
      else                  ref_mem[idx][7:0] = wd[7:0];
    end else begin
      chk(d_lane_oe == 2'b00, "R6", "lanes idle", 32'(d_lane_oe), 0);
    end
    @(negedge clk);
    chk(h_rvalid == x_re, "R8", "h_rvalid", 32'(h_rvalid), 32'(x_re));
    if (x_re)
      chk(h_rdata == x_rdata, wide ? (half ? "R5" : "R4") : "R10", "h_rdata",
          32'(h_rdata), 32'(x_rdata));
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    // ---- narrow mode ----
    do_reset(1'b0);
    access(1'b0, 1'b1, 1'b0, 20'h00012, 16'hBE77);   // R2 byte write
    access(1'b1, 1'b0, 1'b0, 20'h00012, 16'h0000);   // R10 read back low lane
    access(1'b1, 1'b0, 1'b0, 20'h00013, 16'h0000);   // R10 odd address, no shift
    access(1'b1, 1'b0, 1'b1, 20'h00010, 16'h0000);   // R7 halfword refused
    access(1'b1, 1'b1, 1'b0, 20'h00020, 16'h00C4);   // R9 rd+wr -> write only
    for (int n = 0; n < 300; n++)
      access(1'($urandom), 1'($urandom), ($urandom % 4) == 0,
             AW'($urandom % 512), 16'($urandom));
    // ---- wide mode ----
    do_reset(1'b1);
    access(1'b0, 1'b1, 1'b1, 20'h00008, 16'hA1B2);   // R5 word 4
    access(1'b1, 1'b0, 1'b0, 20'h00008, 16'h0000);   // R4 even -> B2
    access(1'b1, 1'b0, 1'b0, 20'h00009, 16'h0000);   // R4 odd -> A1
    access(1'b0, 1'b1, 1'b0, 20'h00009, 16'h0033);   // R6 upper lane
    access(1'b0, 1'b1, 1'b0, 20'h00008, 16'h0044);   // R6 lower lane
    access(1'b1, 1'b0, 1'b1, 20'h00008, 16'h0000);   // R5 expect 3344
    access(1'b1, 1'b0, 1'b1, 20'h00009, 16'h0000);   // R7 odd halfword
    access(1'b0, 1'b1, 1'b1, 20'h00007, 16'hFFFF);   // R7 odd halfword write
    access(1'b1, 1'b0, 1'b1, 20'h00006, 16'h0000);   // R7 no write happened
    access(1'b1, 1'b0, 1'b0, 20'hFFFFF, 16'h0000);   // R3 top address
    access(1'b1, 1'b1, 1'b1, 20'h0000A, 16'h1357);   // R9 write wins
    for (int n = 0; n < 400; n++)
      access(1'($urandom), 1'($urandom), 1'($urandom),
             AW'($urandom % 512), 16'($urandom));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule